// File: doc/BRIEF.md
# Segment Pattern Animation Engine

This block animates a small group of display segments without software involvement. Two pattern registers, A and B, are each as wide as one segment group (eight bits by default). Every animation step pulse, usually from a frame counter, can rotate each register by one bit to the left or to the right. Each register has its own direction control. The two registers are merged bitwise with a selectable AND or OR. The merged pattern then replaces one chosen group of segment outputs. All other segment bits carry the normal segment data unchanged.

A step counter runs next to the patterns and wraps at a programmable top value. Its value is brought out so that the animation phase can be observed. Clearing the enable returns the display to plain segment data and parks the counter at zero. The register contents are kept.

Top module: `seg_anim_engine`

## Requirements
- R1: After reset, both pattern registers hold 0 and the state counter reads 0.
- R2: A write strobe for a register loads its data input at the next clock edge. A write in the same cycle as a step takes priority over that register's rotation.
- R3: Shift control code 1 rotates the register left by one bit (bit i moves to bit i+1, the top bit moves to bit 0). This happens once per step pulse while animation is enabled.
- R4: Shift control code 2 rotates the register right by one bit (bit 0 moves to the top bit) on each enabled step. Codes 0 and 3 leave the register unchanged.
- R5: `pattern_out` is A AND B when `combine_or` is 0 and A OR B when it is 1. It follows the registers and the select input without added latency.
- R6: On each enabled step, the state counter goes to 0 if its value is greater than or equal to `state_top`. Otherwise it increments by 1.
- R7: While `anim_en` is 0, `seg_out` equals `seg_data_in`, step pulses rotate nothing, and the state counter is held at 0.
- R8: While `anim_en` is 1, segment group g (bits g*8 to g*8+7) is replaced by `pattern_out` when `group_sel` equals g. Group 0 covers segments 0 to 7 and group 1 covers segments 8 to 15. All other bits pass `seg_data_in` through.
- R9: `state_out` shows the state counter as a 4-bit value, zero-extended from the 3-bit top range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| anim_en | input | 1 | Animation enable |
| step | input | 1 | One-cycle animation step pulse |
| wr_a | input | 1 | Load strobe for register A |
| din_a | input | 8 | Load value for register A |
| wr_b | input | 1 | Load strobe for register B |
| din_b | input | 8 | Load value for register B |
| shift_a_ctl | input | 2 | Rotation control for A (0 hold, 1 left, 2 right, 3 hold) |
| shift_b_ctl | input | 2 | Rotation control for B (same coding) |
| combine_or | input | 1 | 0: AND merge, 1: OR merge |
| group_sel | input | 1 | Segment group receiving the pattern |
| state_top | input | 3 | Value at which the state counter wraps |
| seg_data_in | input | 16 | Normal segment data |
| pattern_out | output | 8 | Merged animation pattern |
| seg_out | output | 16 | Segment data with the animation applied |
| state_out | output | 4 | Current animation state |

## Verification
Register loads, rotations and state counter updates take effect at the first clock edge after the cycle in which the strobe or step is presented. `pattern_out` and `seg_out` are combinational from those registers and from the select inputs, so they settle in the same cycle once the registers have moved. The bench drives each stimulus on the falling edge and tags the expected outputs with the number of the following rising edge. The monitor compares them shortly after that edge, while the inputs are still held. Write-versus-step priority, wrap with a lowered top, hold codes and disabled steps each get their own stimulus.

// File: rtl/seg_anim_pkg.sv
package seg_anim_pkg;

   // rotation control coding for one pattern register
   typedef enum logic [1:0] {
      SH_NONE  = 2'd0,
      SH_LEFT  = 2'd1,
      SH_RIGHT = 2'd2,
      SH_SPARE = 2'd3
   } shift_ctl_e;

   // merge operator selection
   typedef enum logic {
      MERGE_AND = 1'b0,
      MERGE_OR  = 1'b1
   } merge_op_e;

endpackage

// File: rtl/seg_anim_pattern_reg.sv
module seg_anim_pattern_reg
   import seg_anim_pkg::*;
#(
   parameter int PAT_W    = 8,
   parameter bit CIRCULAR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PAT_W-1:0] load_val,
   input  logic             adv,
   input  shift_ctl_e       ctl,
   output logic [PAT_W-1:0] q
);

   logic [PAT_W-1:0] left_val;
   logic [PAT_W-1:0] right_val;

   // variant: circular rotation or plain shift with zero fill
   generate
      if (CIRCULAR) begin : g_rotate
         assign left_val  = {q[PAT_W-2:0], q[PAT_W-1]};
         assign right_val = {q[0], q[PAT_W-1:1]};
      end else begin : g_shift
         assign left_val  = {q[PAT_W-2:0], 1'b0};
         assign right_val = {1'b0, q[PAT_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= load_val;
      end else if (adv) begin
         case (ctl)
            SH_LEFT:  q <= left_val;
            SH_RIGHT: q <= right_val;
            default:  q <= q;
         endcase
      end
   end

endmodule

// File: rtl/seg_anim_state_ctr.sv
module seg_anim_state_ctr #(
   parameter int TOP_W   = 3,
   parameter int STATE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               step,
   input  logic [TOP_W-1:0]   top,
   output logic [STATE_W-1:0] state
);

   logic [STATE_W-1:0] top_ext;
   logic               at_top;

   assign top_ext = STATE_W'(top);
   assign at_top  = (state >= top_ext);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= '0;
      end else if (!enable) begin
         state <= '0;
      end else if (step) begin
         state <= at_top ? '0 : state + STATE_W'(1);
      end
   end

endmodule

// File: rtl/seg_anim_steer.sv
module seg_anim_steer
   import seg_anim_pkg::*;
#(
   parameter int PAT_W      = 8,
   parameter int NUM_GROUPS = 2,
   localparam int SEG_W     = PAT_W * NUM_GROUPS,
   localparam int LOC_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
   input  logic [PAT_W-1:0] pat_a,
   input  logic [PAT_W-1:0] pat_b,
   input  merge_op_e        op,
   input  logic             enable,
   input  logic [LOC_W-1:0] group_sel,
   input  logic [SEG_W-1:0] seg_in,
   output logic [PAT_W-1:0] pattern,
   output logic [SEG_W-1:0] seg_out
);

   always_comb begin
      case (op)
         MERGE_OR: pattern = pat_a | pat_b;
         default:  pattern = pat_a & pat_b;
      endcase
   end

   // one override slot per segment group
   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
      logic hit;
      assign hit = enable && (group_sel == LOC_W'(g));
      assign seg_out[g*PAT_W +: PAT_W] = hit ? pattern : seg_in[g*PAT_W +: PAT_W];
   end

endmodule

// File: rtl/seg_anim_engine.sv
module seg_anim_engine
   import seg_anim_pkg::*;
#(
   parameter int PAT_W      = 8,
   parameter int NUM_GROUPS = 2,
   parameter int TOP_W      = 3,
   parameter int STATE_W    = 4,
   parameter bit CIRCULAR   = 1'b1,
   localparam int SEG_W     = PAT_W * NUM_GROUPS,
   localparam int LOC_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               anim_en,
   input  logic               step,
   input  logic               wr_a,
   input  logic [PAT_W-1:0]   din_a,
   input  logic               wr_b,
   input  logic [PAT_W-1:0]   din_b,
   input  logic [1:0]         shift_a_ctl,
   input  logic [1:0]         shift_b_ctl,
   input  logic               combine_or,
   input  logic [LOC_W-1:0]   group_sel,
   input  logic [TOP_W-1:0]   state_top,
   input  logic [SEG_W-1:0]   seg_data_in,
   output logic [PAT_W-1:0]   pattern_out,
   output logic [SEG_W-1:0]   seg_out,
   output logic [STATE_W-1:0] state_out
);

   // elaboration-time parameter checks
   if (PAT_W < 2) begin : g_bad_pat_w
      $error("seg_anim_engine: PAT_W must be at least 2");
   end
   if (NUM_GROUPS < 2) begin : g_bad_groups
      $error("seg_anim_engine: NUM_GROUPS must be at least 2");
   end
   if (STATE_W < TOP_W) begin : g_bad_state_w
      $error("seg_anim_engine: STATE_W must cover TOP_W");
   end

   logic               adv;
   logic [PAT_W-1:0]   pat_a_q;
   logic [PAT_W-1:0]   pat_b_q;
   logic [STATE_W-1:0] state_q;

   assign adv = anim_en & step;

   seg_anim_pattern_reg #(.PAT_W(PAT_W), .CIRCULAR(CIRCULAR)) u_reg_a (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_a),
      .load_val (din_a),
      .adv      (adv),
      .ctl      (shift_ctl_e'(shift_a_ctl)),
      .q        (pat_a_q)
   );

   seg_anim_pattern_reg #(.PAT_W(PAT_W), .CIRCULAR(CIRCULAR)) u_reg_b (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_b),
      .load_val (din_b),
      .adv      (adv),
      .ctl      (shift_ctl_e'(shift_b_ctl)),
      .q        (pat_b_q)
   );

   seg_anim_state_ctr #(.TOP_W(TOP_W), .STATE_W(STATE_W)) u_state (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (anim_en),
      .step   (step),
      .top    (state_top),
      .state  (state_q)
   );

   seg_anim_steer #(.PAT_W(PAT_W), .NUM_GROUPS(NUM_GROUPS)) u_steer (
      .pat_a     (pat_a_q),
      .pat_b     (pat_b_q),
      .op        (merge_op_e'(combine_or)),
      .enable    (anim_en),
      .group_sel (group_sel),
      .seg_in    (seg_data_in),
      .pattern   (pattern_out),
      .seg_out   (seg_out)
   );

   assign state_out = state_q;

endmodule

// File: rtl/seg_anim_checker.sv
module seg_anim_checker #(
   parameter int PAT_W   = 8,
   parameter int SEG_W   = 16,
   parameter int TOP_W   = 3,
   parameter int STATE_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               anim_en,
   input logic               step,
   input logic               wr_a,
   input logic [PAT_W-1:0]   din_a,
   input logic [1:0]         shift_a_ctl,
   input logic [TOP_W-1:0]   state_top,
   input logic [SEG_W-1:0]   seg_data_in,
   input logic [SEG_W-1:0]   seg_out,
   input logic [PAT_W-1:0]   a_q,
   input logic [STATE_W-1:0] state_q
);

   a_r2_load_a: assert property (@(posedge clk) disable iff (!rst_n)
      wr_a |=> (a_q == $past(din_a)));

   a_r3_rotate_left: assert property (@(posedge clk) disable iff (!rst_n)
      (anim_en && step && !wr_a && shift_a_ctl == 2'd1)
      |=> (a_q == {$past(a_q[PAT_W-2:0]), $past(a_q[PAT_W-1])}));

   a_r4_rotate_right: assert property (@(posedge clk) disable iff (!rst_n)
      (anim_en && step && !wr_a && shift_a_ctl == 2'd2)
      |=> (a_q == {$past(a_q[0]), $past(a_q[PAT_W-1:1])}));

   a_r4_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_a && (!(anim_en && step) || shift_a_ctl == 2'd0 || shift_a_ctl == 2'd3))
      |=> $stable(a_q));

   a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (anim_en && step && state_q >= STATE_W'(state_top)) |=> (state_q == '0));

   a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (anim_en && step && state_q < STATE_W'(state_top))
      |=> (state_q == $past(state_q) + STATE_W'(1)));

   a_r7_state_parked: assert property (@(posedge clk) disable iff (!rst_n)
      !anim_en |=> (state_q == '0));

   a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      !anim_en |-> (seg_out == seg_data_in));

endmodule

bind seg_anim_engine seg_anim_checker #(
   .PAT_W   (PAT_W),
   .SEG_W   (SEG_W),
   .TOP_W   (TOP_W),
   .STATE_W (STATE_W)
) u_seg_anim_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .anim_en     (anim_en),
   .step        (step),
   .wr_a        (wr_a),
   .din_a       (din_a),
   .shift_a_ctl (shift_a_ctl),
   .state_top   (state_top),
   .seg_data_in (seg_data_in),
   .seg_out     (seg_out),
   .a_q         (pat_a_q),
   .state_q     (state_q)
);

// File: tb/test_seg_anim_engine.sv
`timescale 1ns/100ps
module test_seg_anim_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        anim_en = 1'b0;
   logic        step = 1'b0;
   logic        wr_a = 1'b0;
   logic [7:0]  din_a = '0;
   logic        wr_b = 1'b0;
   logic [7:0]  din_b = '0;
   logic [1:0]  shift_a_ctl = '0;
   logic [1:0]  shift_b_ctl = '0;
   logic        combine_or = 1'b0;
   logic        group_sel = 1'b0;
   logic [2:0]  state_top = '0;
   logic [15:0] seg_data_in = '0;
   logic [7:0]  pattern_out;
   logic [15:0] seg_out;
   logic [3:0]  state_out;

   always #2.5 clk = ~clk;

   seg_anim_engine i_seg_anim_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .anim_en     (anim_en),
      .step        (step),
      .wr_a        (wr_a),
      .din_a       (din_a),
      .wr_b        (wr_b),
      .din_b       (din_b),
      .shift_a_ctl (shift_a_ctl),
      .shift_b_ctl (shift_b_ctl),
      .combine_or  (combine_or),
      .group_sel   (group_sel),
      .state_top   (state_top),
      .seg_data_in (seg_data_in),
      .pattern_out (pattern_out),
      .seg_out     (seg_out),
      .state_out   (state_out)
   );

   typedef struct {
      logic [7:0]  pat;
      logic [15:0] seg;
      logic [3:0]  st;
      int          due;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   checks = 0;
   int   failures = 0;
   bit   done = 1'b0;

   // independent model state
   logic [7:0] m_a = '0;
   logic [7:0] m_b = '0;
   logic [3:0] m_st = '0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [7:0] model_rot(input logic [7:0] v, input logic [1:0] c);
      if (c == 2'd1) return {v[6:0], v[7]};
      if (c == 2'd2) return {v[0], v[7:1]};
      return v;
   endfunction

   // driver: applies one cycle of stimulus on the falling edge and queues the expectation
   task automatic drive(input logic en, input logic stp,
                        input logic wa, input logic [7:0] da,
                        input logic wb, input logic [7:0] db,
                        input logic [1:0] ca, input logic [1:0] cb,
                        input logic orr, input logic hi, input logic [2:0] top,
                        input logic [15:0] sin, input string tag);
      exp_t e;
      logic [7:0] p;
      @(negedge clk);
      anim_en = en; step = stp; wr_a = wa; din_a = da; wr_b = wb; din_b = db;
      shift_a_ctl = ca; shift_b_ctl = cb; combine_or = orr; group_sel = hi;
      state_top = top; seg_data_in = sin;
      m_a = wa ? da : ((en && stp) ? model_rot(m_a, ca) : m_a);
      m_b = wb ? db : ((en && stp) ? model_rot(m_b, cb) : m_b);
      if (!en) m_st = 4'd0;
      else if (stp) m_st = (m_st >= {1'b0, top}) ? 4'd0 : m_st + 4'd1;
      p = orr ? (m_a | m_b) : (m_a & m_b);
      e.pat = p;
      e.seg = !en ? sin : (hi ? {p, sin[7:0]} : {sin[15:8], p});
      e.st  = m_st;
      e.due = cyc + 1;
      e.tag = tag;
      q.push_back(e);
   endtask

   // monitor: compares after the due rising edge, before the next stimulus
   initial begin
      forever begin
         @(posedge clk);
         #1;
         while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (pattern_out !== e.pat || seg_out !== e.seg || state_out !== e.st) begin
               failures++;
               $display("FAIL %s: actual pat=%h seg=%h st=%0d expected pat=%h seg=%h st=%0d",
                        e.tag, pattern_out, seg_out, state_out, e.pat, e.seg, e.st);
            end
         end
      end
   end

   initial begin
      #200000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset values, R7 bypass while disabled
      drive(0,0, 0,8'h00, 0,8'h00, 2'd0,2'd0, 0,0,3'd3, 16'hABCD, "R1 reset state");
      // R2 loads, R5 AND merge
      drive(0,0, 1,8'h81, 1,8'h0F, 2'd0,2'd0, 0,0,3'd3, 16'h1234, "R2 load both");
      drive(0,0, 0,8'h00, 0,8'h00, 2'd0,2'd0, 1,0,3'd3, 16'h1234, "R5 OR merge");
      // R7 step ignored while disabled
      drive(0,1, 0,8'h00, 0,8'h00, 2'd1,2'd2, 1,0,3'd3, 16'h5A5A, "R7 step while disabled");
      // R3 left / R4 right, R6 counting, R8 low group, R9 readback
      for (int i = 0; i < 5; i++)
         drive(1,1, 0,8'h00, 0,8'h00, 2'd1,2'd2, 1,0,3'd3, 16'hFFFF, "R3 R6 R9 rotate and count");
      // R8 idle cycle without step keeps state
      drive(1,0, 0,8'h00, 0,8'h00, 2'd1,2'd2, 0,0,3'd3, 16'h0000, "R8 low group AND");
      // R4 codes 3 and 0 hold
      drive(1,1, 0,8'h00, 0,8'h00, 2'd3,2'd0, 1,0,3'd3, 16'h0F0F, "R4 hold codes");
      // R8 high group
      drive(1,1, 0,8'h00, 0,8'h00, 2'd2,2'd1, 1,1,3'd3, 16'h00FF, "R8 high group");
      drive(1,0, 0,8'h00, 0,8'h00, 2'd0,2'd0, 0,1,3'd3, 16'hFFFF, "R8 high group AND");
      // R2 write wins over step
      drive(1,1, 1,8'h55, 0,8'h00, 2'd1,2'd1, 1,0,3'd3, 16'h0000, "R2 write beats step");
      // R6 advance then lower top below state
      drive(1,1, 0,8'h00, 0,8'h00, 2'd0,2'd0, 1,0,3'd7, 16'h0000, "R6 count up");
      drive(1,1, 0,8'h00, 0,8'h00, 2'd0,2'd0, 1,0,3'd7, 16'h0000, "R6 count up");
      drive(1,1, 0,8'h00, 0,8'h00, 2'd0,2'd0, 1,0,3'd1, 16'h0000, "R6 wrap above top");
      // R6 top 0 keeps state at 0
      drive(1,1, 0,8'h00, 0,8'h00, 2'd0,2'd0, 1,0,3'd0, 16'h0000, "R6 top zero");
      // R9 reach top 7
      for (int i = 0; i < 8; i++)
         drive(1,1, 0,8'h00, 0,8'h00, 2'd2,2'd1, 0,1,3'd7, 16'h3C3C, "R9 full range");
      // R7 disable parks state and restores data
      drive(0,1, 0,8'h00, 0,8'h00, 2'd1,2'd1, 1,1,3'd7, 16'hC3C3, "R7 disable");
      drive(0,0, 0,8'h00, 0,8'h00, 2'd0,2'd0, 1,1,3'd7, 16'h9999, "R7 stays bypassed");
      @(negedge clk);
      anim_en = 1'b0; step = 1'b0; wr_a = 1'b0; wr_b = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule